// File: doc/BRIEF.md
# Preemptible Oversampling Accumulator

This block averages a converter's regular-channel results by summing a programmed power-of-two number of them in a running buffer. Once the last sample of a batch arrives, the block shifts the total right by a programmed amount, presents the result and raises a one-cycle done strobe. The buffer then starts the next batch from zero.

Higher-priority injected conversions can interrupt a batch. An injected window opens on `injStart` and closes on `injEnd`. While the window is open, regular results are not counted. The `resumeMode` input decides what happens to a partial batch when a window opens. With `resumeMode` at 0, the partial sum and sample count are frozen and the batch continues after the window. With `resumeMode` at 1, they are thrown away and the batch starts again from its first sample after the window. The `enable` input acts as the start flag. The mode input may only change while `enable` is low.

Top module: `oversample_accum`

## Requirements
- R1: After reset, `doneOut` is 0 and `avgOut` is 0.
- R2: Each accepted regular sample is added to the buffer. The Nth accepted sample, where N = 2^ratioLog2, completes a batch. In the cycle after that sample, `doneOut` is 1 and `avgOut` equals (sum of the N samples) >> shiftAmt. The buffer and count then start again from zero.
- R3: `ratioLog2` selects batches of 2 to 256 samples. A value of 0 acts as 1, and values above 8 act as 8. `shiftAmt` above 8 acts as 8. The 20-bit buffer holds 256 full-scale 12-bit samples without overflow.
- R4: With `resumeMode`=0, an injected window keeps the partial sum and count. This window runs from the `injStart` cycle through the `injEnd` cycle inclusive, and `injStart` wins if both pulse together. Accumulation continues from the kept values after the window.
- R5: With `resumeMode`=1 and `enable`=1, an `injStart` pulse clears the partial sum and count. The next batch begins with the first regular sample accepted after the window.
- R6: A `regValid` strobe is ignored in two cases: inside an injected window, or in a cycle where `injValid` is also 1.
- R7: `doneOut` is high for exactly one cycle per batch. `avgOut` holds its value until the next completion.
- R8: While `enable` is 0, the partial sum and count are cleared and regular samples are ignored. No completion occurs and `avgOut` is held.
- R9: `resumeMode` stays stable while `enable` is 1 on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Start flag; low clears the partial batch |
| resumeMode | input | 1 | 0: freeze and continue on preemption, 1: discard and restart |
| ratioLog2 | input | 4 | log2 of samples per batch (1..8) |
| shiftAmt | input | 4 | Right shift applied to the sum (0..8) |
| regValid | input | 1 | Regular result strobe |
| regData | input | 12 | Regular result value |
| injValid | input | 1 | Injected result strobe |
| injStart | input | 1 | Injected sequence start pulse |
| injEnd | input | 1 | Injected sequence end pulse |
| avgOut | output | 20 | Shifted batch sum, held between completions |
| doneOut | output | 1 | One-cycle batch-complete strobe |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle done strobe, the held result, the frozen count during an injected window, the clear on a resumed-mode preemption, the count bound and the locked mode input. Other behaviour can only be shown by the bench's scenarios. This includes the arithmetic value of each average and the clamping of out-of-range ratio and shift settings. It also includes the contrast between the continued and restarted sums after preemption, and the discarding of a batch when `enable` drops.

// File: rtl/oversample_pkg.sv
package oversample_pkg;
  typedef struct packed {
    logic clearSum;
    logic addSample;
    logic finish;
  } accCmd_t;
endpackage

// File: rtl/oversample_ctrl.sv
module oversample_ctrl
  import oversample_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  localparam int SEL_W = $clog2(MAX_LOG2 + 1),
  localparam int CNT_W = MAX_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             resumeMode,
  input  logic [SEL_W-1:0] ratioLog2,
  input  logic             regValid,
  input  logic             injValid,
  input  logic             injStart,
  input  logic             injEnd,
  output accCmd_t          cmd
);
  logic [CNT_W-1:0] sampleCnt;
  logic [SEL_W-1:0] effLog;
  logic [CNT_W:0]   lastIdx;
  logic             injActive;
  logic             injBusy;
  logic             accept;
  logic             lastSample;

  always_comb begin
    if (ratioLog2 == '0) effLog = SEL_W'(1);
    else if (ratioLog2 > SEL_W'(MAX_LOG2)) effLog = SEL_W'(MAX_LOG2);
    else effLog = ratioLog2;
  end

  assign lastIdx    = ({{CNT_W{1'b0}}, 1'b1} << effLog) - 1'b1;
  assign injBusy    = injStart | injActive;
  assign accept     = enable & regValid & ~injBusy & ~injValid;
  assign lastSample = ({1'b0, sampleCnt} == lastIdx);

  always_comb begin
    cmd.clearSum  = ~enable | (injStart & resumeMode);
    cmd.addSample = accept & ~lastSample;
    cmd.finish    = accept & lastSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) injActive <= 1'b0;
    else if (injStart) injActive <= 1'b1;
    else if (injEnd) injActive <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleCnt <= '0;
    else if (cmd.clearSum || cmd.finish) sampleCnt <= '0;
    else if (cmd.addSample) sampleCnt <= sampleCnt + 1'b1;
  end

  p_inj_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && injActive && !injStart && regValid) |=> $stable(sampleCnt));
  p_continue_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && injStart && !resumeMode) |=> $stable(sampleCnt));
  p_resume_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && injStart && resumeMode) |=> (sampleCnt == '0));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $stable(ratioLog2)) |-> ({1'b0, sampleCnt} <= lastIdx || $changed(ratioLog2)));
endmodule

// File: rtl/oversample_datapath.sv
module oversample_datapath
  import oversample_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG2 = 8,
  localparam int SEL_W = $clog2(MAX_LOG2 + 1),
  localparam int ACC_W = SAMPLE_W + MAX_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  accCmd_t             cmd,
  input  logic [SAMPLE_W-1:0] regData,
  input  logic [SEL_W-1:0]    shiftAmt,
  output logic [ACC_W-1:0]    avgOut,
  output logic                doneOut
);
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] sumNext;
  logic [SEL_W-1:0] effShift;

  assign effShift = (shiftAmt > SEL_W'(MAX_LOG2)) ? SEL_W'(MAX_LOG2) : shiftAmt;
  assign sumNext  = accSum + ACC_W'(regData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum  <= '0;
      avgOut  <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= cmd.finish;
      if (cmd.clearSum) accSum <= '0;
      else if (cmd.finish) begin
        accSum <= '0;
        avgOut <= sumNext >> effShift;
      end else if (cmd.addSample) accSum <= sumNext;
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(avgOut));
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearSum |=> (accSum == '0) && !doneOut);
endmodule

// File: rtl/oversample_accum.sv
module oversample_accum
  import oversample_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LOG2 = 8,
  localparam int SEL_W = $clog2(MAX_LOG2 + 1),
  localparam int ACC_W = SAMPLE_W + MAX_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                resumeMode,
  input  logic [SEL_W-1:0]    ratioLog2,
  input  logic [SEL_W-1:0]    shiftAmt,
  input  logic                regValid,
  input  logic [SAMPLE_W-1:0] regData,
  input  logic                injValid,
  input  logic                injStart,
  input  logic                injEnd,
  output logic [ACC_W-1:0]    avgOut,
  output logic                doneOut
);
  accCmd_t cmd;

  oversample_ctrl #(.MAX_LOG2(MAX_LOG2)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .resumeMode(resumeMode),
    .ratioLog2(ratioLog2), .regValid(regValid), .injValid(injValid),
    .injStart(injStart), .injEnd(injEnd), .cmd(cmd)
  );

  oversample_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_LOG2(MAX_LOG2)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regData(regData),
    .shiftAmt(shiftAmt), .avgOut(avgOut), .doneOut(doneOut)
  );

  p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> $stable(resumeMode));
endmodule

// File: tb/test_oversample_accum.sv
module test_oversample_accum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0, resumeMode = 1'b0;
  logic [3:0]  ratioLog2 = 4'd1, shiftAmt = 4'd0;
  logic        regValid = 1'b0, injValid = 1'b0, injStart = 1'b0, injEnd = 1'b0;
  logic [11:0] regData = '0;
  logic [19:0] avgOut;
  logic        doneOut;

  int total = 0, bad = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [19:0] mSum = '0, mRes = '0;
  int          mCnt = 0;
  bit          mInj = 0, mDone = 0;

  oversample_accum i_oversample_accum (.*);

  always #4 clk = ~clk;

  function automatic int effLog(input logic [3:0] r);
    if (r == 0) return 1;
    if (r > 8) return 8;
    return int'(r);
  endfunction

  function automatic int effShift(input logic [3:0] s);
    return (s > 8) ? 8 : int'(s);
  endfunction

  task automatic check(input string req, input logic [19:0] gotRes, input logic gotDone);
    total++;
    if (gotRes !== mRes || gotDone !== mDone) begin
      bad++;
      $display("FAIL %s: avgOut=%0d doneOut=%0b expected avgOut=%0d doneOut=%0b",
               req, gotRes, gotDone, mRes, mDone);
    end
  endtask

  task automatic tick(input bit rv, input logic [11:0] d, input bit iv, input bit is, input bit ie);
    bit busy;
    regValid = rv; regData = d; injValid = iv; injStart = is; injEnd = ie;
    @(posedge clk);
    busy = is | mInj;
    mDone = 0;
    if (!enable) begin mSum = 0; mCnt = 0; end
    else if (is && resumeMode) begin mSum = 0; mCnt = 0; end
    else if (rv && !busy && !iv) begin
      if (mCnt == (1 << effLog(ratioLog2)) - 1) begin
        mRes = (mSum + 20'(d)) >> effShift(shiftAmt);
        mDone = 1; mSum = 0; mCnt = 0;
      end else begin
        mSum = mSum + 20'(d); mCnt++;
      end
    end
    if (is) mInj = 1; else if (ie) mInj = 0;
    #1;
    check(curReq, avgOut, doneOut);
    @(negedge clk);
  endtask

  task automatic setMode(input bit m, input logic [3:0] r, input logic [3:0] s);
    enable = 0; tick(0, 0, 0, 0, 0);
    resumeMode = m; ratioLog2 = r; shiftAmt = s;
    tick(0, 0, 0, 0, 0);
    enable = 1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    curReq = "R1"; #1; check("R1", avgOut, doneOut);
    rstN = 1'b1;
    tick(0, 0, 0, 0, 0);

    curReq = "R2"; setMode(0, 4'd1, 4'd1);
    tick(1, 12'd100, 0, 0, 0); tick(1, 12'd200, 0, 0, 0);
    tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);

    curReq = "R3"; setMode(0, 4'd8, 4'd8);
    for (int i = 0; i < 256; i++) tick(1, 12'hFFF, 0, 0, 0);
    tick(0, 0, 0, 0, 0);
    curReq = "R3"; setMode(0, 4'd0, 4'd15);
    for (int i = 0; i < 4; i++) tick(1, 12'd3000 + 12'(i), 0, 0, 0);
    setMode(0, 4'd12, 4'd2);
    for (int i = 0; i < 300; i++) tick(1, 12'(i * 7), 0, 0, 0);

    curReq = "R4"; setMode(0, 4'd2, 4'd0);
    tick(1, 12'd10, 0, 0, 0); tick(1, 12'd20, 0, 0, 0);
    tick(1, 12'd999, 0, 1, 0); tick(1, 12'd999, 1, 0, 0);
    tick(1, 12'd999, 0, 0, 1);
    tick(1, 12'd30, 0, 0, 0); tick(1, 12'd40, 0, 0, 0); tick(0, 0, 0, 0, 0);

    curReq = "R5"; setMode(1, 4'd2, 4'd0);
    tick(1, 12'd10, 0, 0, 0); tick(1, 12'd20, 0, 0, 0);
    tick(0, 0, 0, 1, 0); tick(1, 12'd500, 0, 0, 1);
    for (int i = 0; i < 4; i++) tick(1, 12'd1 + 12'(i), 0, 0, 0);
    tick(0, 0, 0, 0, 0);

    curReq = "R6"; setMode(0, 4'd1, 4'd0);
    tick(1, 12'd5, 1, 0, 0); tick(1, 12'd6, 0, 0, 0);
    tick(1, 12'd7, 1, 0, 0); tick(1, 12'd8, 0, 0, 0); tick(0, 0, 0, 0, 0);

    curReq = "R8"; setMode(0, 4'd2, 4'd0);
    tick(1, 12'd50, 0, 0, 0); tick(1, 12'd60, 0, 0, 0);
    enable = 0; tick(1, 12'd70, 0, 0, 0); tick(1, 12'd80, 0, 0, 0);
    enable = 1;
    for (int i = 0; i < 4; i++) tick(1, 12'd1, 0, 0, 0);
    tick(0, 0, 0, 0, 0);

    curReq = "R7";
    for (int blk = 0; blk < 40; blk++) begin
      setMode(1'($urandom_range(0, 1)), 4'($urandom_range(0, 10)), 4'($urandom_range(0, 10)));
      for (int c = 0; c < 400; c++) begin
        bit is = ($urandom_range(0, 40) == 0);
        bit ie = ($urandom_range(0, 6) == 0);
        tick(1'($urandom_range(0, 3) != 0), 12'($urandom), ($urandom_range(0, 15) == 0), is, ie);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule